// File: doc/BRIEF.md
# Machine control register with coprocessor dispatch gate

This block holds the processor's 32-bit machine control word and uses it to rule on floating-point work. Software loads the word through a write port. A write that would turn on paging while protection stays off is refused and flagged as a general-protection fault. The hardware changes the task-switched flag on its own: a task-switch strobe sets it, and a dedicated clear strobe resets it. The word also gives a decoded operating mode. That mode is real-address, protected, or protected with paging.

When the dispatch stage presents a floating-point or WAIT instruction, the gate returns a verdict in the same cycle. The verdict is either execute or a device-not-available trap. It depends on the emulation, monitor-coprocessor and task-switched flags. This allows lazy saving of coprocessor state: after a task switch, the first floating-point instruction traps, and the handler saves the context and then clears the flag. The extension-type flag is loaded from a strap pin while reset is held.

Top module: `mcr_ctrl`

## Requirements
- R1: While reset is held and after it is released, the control word is zero except bit 4 (extension type), which equals the strap input; the mode output reads real-address (2'b00).
- R2: A legal write loads bits 0 (protection), 1 (monitor), 2 (emulation), 3 (task switched), 4 (extension type), 5 (numeric error), 16 (write protect) and 31 (paging) at the next clock edge; every other bit always reads 0.
- R3: A write with bit 31 = 1 and bit 0 = 0 raises gp_fault in the same cycle only, and leaves the control word unchanged.
- R4: The mode output is 2'b00 when protection is 0, 2'b01 when protection is 1 and paging is 0, and 2'b11 when both are 1; the value 2'b10 never appears.
- R5: A non-WAIT instruction (insn_vld=1, insn_is_wait=0) traps when bit 2 or bit 3 is 1, and otherwise executes.
- R6: A WAIT instruction (insn_vld=1, insn_is_wait=1) traps only when bits 1 and 3 are both 1; bit 2 has no effect on it.
- R7: ts_set makes bit 3 equal to 1 at the next edge, and ts_clr makes it 0 and leaves the other bits alone. When both strobes arrive together, the set wins. The strobes take precedence over a write in the same cycle.
- R8: The verdict is combinational on the current control word. Exactly one of trap_dna and exec_ok is high while insn_vld is 1, and both are low otherwise.
- R9: The extension-type bit never changes a verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fullcop | input | 1 | Coprocessor type strap, loaded into bit 4 during reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Value to write |
| ts_set | input | 1 | Task-switch event, sets bit 3 |
| ts_clr | input | 1 | Clear command for bit 3 |
| insn_vld | input | 1 | An instruction of the coprocessor class is being dispatched |
| insn_is_wait | input | 1 | 1 = WAIT form, 0 = other floating-point instruction |
| ctl_q | output | 32 | Current control word |
| mode | output | 2 | Decoded operating mode |
| gp_fault | output | 1 | Illegal-write fault pulse |
| trap_dna | output | 1 | Device-not-available verdict |
| exec_ok | output | 1 | Execute verdict |

## Verification
The bench aims at three corner cases.
- A WAIT while emulation is on and the task-switched flag is clear must execute. A gate that reused the floating-point rule would trap there.
- A paging-without-protection write, issued in the same cycle as a task-switch strobe, must still set the task-switched flag but change no other bit. A design that applied the rejected word, or dropped the strobe, would show the wrong value on the next cycle.
- Simultaneous set and clear strobes must leave the flag set. Writes with every unimplemented bit set must read back with those bits clear.

Random cycles, compared against a behavioural model, cover the rest of the flag combinations.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    localparam int unsigned XLEN = 32;

    localparam int unsigned B_PE = 0;
    localparam int unsigned B_MP = 1;
    localparam int unsigned B_EM = 2;
    localparam int unsigned B_TS = 3;
    localparam int unsigned B_ET = 4;
    localparam int unsigned B_NE = 5;
    localparam int unsigned B_WP = 16;
    localparam int unsigned B_PG = 31;

    localparam logic [XLEN-1:0] IMPL_MASK =
        (XLEN'(1) << B_PE) | (XLEN'(1) << B_MP) | (XLEN'(1) << B_EM) |
        (XLEN'(1) << B_TS) | (XLEN'(1) << B_ET) | (XLEN'(1) << B_NE) |
        (XLEN'(1) << B_WP) | (XLEN'(1) << B_PG);

    typedef enum logic [1:0] {
        MODE_REAL    = 2'b00,
        MODE_PROT    = 2'b01,
        MODE_PROT_PG = 2'b11
    } mode_e;

    typedef struct packed {
        logic pg;
        logic wp;
        logic ne;
        logic et;
        logic ts;
        logic em;
        logic mp;
        logic pe;
    } flags_t;

    function automatic logic [XLEN-1:0] flags_pack(input flags_t f);
        logic [XLEN-1:0] w;
        w       = '0;
        w[B_PE] = f.pe;
        w[B_MP] = f.mp;
        w[B_EM] = f.em;
        w[B_TS] = f.ts;
        w[B_ET] = f.et;
        w[B_NE] = f.ne;
        w[B_WP] = f.wp;
        w[B_PG] = f.pg;
        return w;
    endfunction

    function automatic flags_t flags_unpack(input logic [XLEN-1:0] w);
        flags_t f;
        f.pe = w[B_PE];
        f.mp = w[B_MP];
        f.em = w[B_EM];
        f.ts = w[B_TS];
        f.et = w[B_ET];
        f.ne = w[B_NE];
        f.wp = w[B_WP];
        f.pg = w[B_PG];
        return f;
    endfunction

endpackage

// File: rtl/mcr_regfile.sv
module mcr_regfile
    import mcr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_fullcop,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic            ts_set,
    input  logic            ts_clr,
    output flags_t          flags_o,
    output logic            gp_fault
);

    typedef struct packed {
        flags_t flags;
    } reg_state_t;

    reg_state_t st_d, st_q;
    flags_t     wr_flags;
    logic       wr_bad;

    always_comb begin
        wr_flags = flags_unpack(wr_data & IMPL_MASK);
        wr_bad   = wr_en && wr_flags.pg && !wr_flags.pe;
        st_d     = st_q;
        if (wr_en && !wr_bad) begin
            st_d.flags = wr_flags;
        end
        if (ts_set) begin
            st_d.flags.ts = 1'b1;
        end else if (ts_clr) begin
            st_d.flags.ts = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.flags.et <= strap_fullcop;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o  = st_q.flags;
    assign gp_fault = wr_bad;

    p_bad_write_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_fault && !ts_set && !ts_clr) |=> $stable(flags_o));

    p_no_paging_without_prot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags_o.pg && !flags_o.pe));

    p_set_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ts_set |=> flags_o.ts);

    p_clr_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_clr && !ts_set) |=> !flags_o.ts);

endmodule

// File: rtl/mcr_mode_dec.sv
module mcr_mode_dec
    import mcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pe,
    input  logic       pg,
    output logic [1:0] mode
);

    mode_e m;

    always_comb begin
        if (!pe) begin
            m = MODE_REAL;
        end else if (pg) begin
            m = MODE_PROT_PG;
        end else begin
            m = MODE_PROT;
        end
    end

    assign mode = m;

    p_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b10);

endmodule

// File: rtl/mcr_fp_gate.sv
module mcr_fp_gate
    import mcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic em,
    input  logic mp,
    input  logic ts,
    input  logic insn_vld,
    input  logic insn_is_wait,
    output logic trap_dna,
    output logic exec_ok
);

    logic block;

    always_comb begin
        if (insn_is_wait) begin
            block = mp && ts;
        end else begin
            block = em || ts;
        end
        trap_dna = insn_vld && block;
        exec_ok  = insn_vld && !block;
    end

    p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld |-> ($countones({trap_dna, exec_ok}) == 1));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_vld |-> (!trap_dna && !exec_ok));

    p_wait_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld && insn_is_wait && !ts) |-> exec_ok);

endmodule

// File: rtl/mcr_ctrl.sv
module mcr_ctrl
    import mcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_fullcop,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        ts_set,
    input  logic        ts_clr,
    input  logic        insn_vld,
    input  logic        insn_is_wait,
    output logic [31:0] ctl_q,
    output logic [1:0]  mode,
    output logic        gp_fault,
    output logic        trap_dna,
    output logic        exec_ok
);

    flags_t flags;

    mcr_regfile u_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_fullcop (strap_fullcop),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .ts_set        (ts_set),
        .ts_clr        (ts_clr),
        .flags_o       (flags),
        .gp_fault      (gp_fault)
    );

    mcr_mode_dec u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .pe    (flags.pe),
        .pg    (flags.pg),
        .mode  (mode)
    );

    mcr_fp_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .em           (flags.em),
        .mp           (flags.mp),
        .ts           (flags.ts),
        .insn_vld     (insn_vld),
        .insn_is_wait (insn_is_wait),
        .trap_dna     (trap_dna),
        .exec_ok      (exec_ok)
    );

    assign ctl_q = flags_pack(flags);

    p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q & ~IMPL_MASK) == 32'h0);

endmodule

// File: tb/sim_mcr_ctrl.sv
module sim_mcr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_fullcop = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ts_set = 1'b0;
    logic        ts_clr = 1'b0;
    logic        insn_vld = 1'b0;
    logic        insn_is_wait = 1'b0;
    logic [31:0] ctl_q;
    logic [1:0]  mode;
    logic        gp_fault;
    logic        trap_dna;
    logic        exec_ok;

    int checks = 0;
    int failures = 0;
    logic [31:0] mdl = '0;
    bit done = 1'b0;

    localparam logic [31:0] MASK = 32'h8001_003F;

    always #2 clk = ~clk;

    mcr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .strap_fullcop(strap_fullcop),
        .wr_en(wr_en), .wr_data(wr_data), .ts_set(ts_set), .ts_clr(ts_clr),
        .insn_vld(insn_vld), .insn_is_wait(insn_is_wait),
        .ctl_q(ctl_q), .mode(mode), .gp_fault(gp_fault),
        .trap_dna(trap_dna), .exec_ok(exec_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every output against the model; called just before a rising edge.
    task automatic compare_all();
        logic [1:0] emode;
        logic       blk;
        logic       egp;
        emode = mdl[0] ? (mdl[31] ? 2'b11 : 2'b01) : 2'b00;
        blk   = insn_is_wait ? (mdl[1] && mdl[3]) : (mdl[2] || mdl[3]);
        egp   = wr_en && wr_data[31] && !wr_data[0];
        chk("R2 word", ctl_q, mdl);
        chk("R4 mode", {30'd0, mode}, {30'd0, emode});
        chk("R3 gp", {31'd0, gp_fault}, {31'd0, egp});
        chk(insn_is_wait ? "R6 wait trap" : "R5 fp trap", {31'd0, trap_dna}, {31'd0, insn_vld && blk});
        chk("R8 exec", {31'd0, exec_ok}, {31'd0, insn_vld && !blk});
    endtask

    task automatic model_step();
        if (wr_en && !(wr_data[31] && !wr_data[0])) mdl = wr_data & MASK;
        if (ts_set) mdl[3] = 1'b1;
        else if (ts_clr) mdl[3] = 1'b0;
    endtask

    // Drive at negedge, check before posedge, advance model at posedge.
    task automatic cyc(input logic w, input logic [31:0] d, input logic s, input logic c,
                       input logic v, input logic wt);
        @(negedge clk);
        wr_en = w; wr_data = d; ts_set = s; ts_clr = c; insn_vld = v; insn_is_wait = wt;
        #1;
        compare_all();
        @(posedge clk);
        model_step();
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset with strap high
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset word strap1", ctl_q, 32'h10);
        chk("R1 reset mode", {30'd0, mode}, 32'd0);
        rst_n = 1'b1;
        mdl = 32'h10;
        cyc(0, 0, 0, 0, 0, 0);

        // R2: all ones write, unimplemented bits drop
        cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        @(negedge clk); #1;
        chk("R2 implemented bits only", ctl_q, MASK);
        // R3: paging without protection, alongside a set strobe
        cyc(1, 32'h0000_0000, 0, 0, 0, 0);
        cyc(1, 32'h8000_0002, 1, 0, 0, 0);
        @(negedge clk); #1;
        chk("R3 rejected word, R7 ts set", ctl_q, 32'h0000_0008);
        // R7: set and clear together, set wins
        cyc(0, 0, 1, 1, 0, 0);
        @(negedge clk); #1;
        chk("R7 set wins", ctl_q[3] ? 32'd1 : 32'd0, 32'd1);
        // R6: WAIT with EM=1, TS=0 executes
        cyc(1, 32'h0000_0004, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 1);
        @(negedge clk); #1;
        chk("R6 wait under emulation", {31'd0, exec_ok}, 32'd1);
        // R5: FP with EM=1 traps
        cyc(0, 0, 0, 0, 1, 0);
        // R9: ET toggles do not change verdicts for each flag combination
        for (int k = 0; k < 16; k++) begin
            cyc(1, {28'd0, k[3:0]} << 1, 0, 0, 1, k[0]);
            cyc(0, 0, 0, 0, 1, 0);
            cyc(0, 0, 0, 0, 1, 1);
        end
        // R4: mode sequence real -> prot -> prot+paging
        cyc(1, 32'h0000_0001, 0, 0, 0, 0);
        cyc(1, 32'h8000_0001, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        // R7: clear leaves other bits
        cyc(1, 32'h8001_003F, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        @(negedge clk); #1;
        chk("R7 clear only ts", ctl_q, 32'h8001_0037);

        // random cycles
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            logic [31:0] d;
            r = $urandom;
            d = $urandom;
            if (r[7:6] == 2'b00) d[31] = 1'b0;
            if (r[9:8] == 2'b00) d[0] = 1'b0;
            cyc(r[0] & r[1], d, r[2] & r[3], r[4], r[5] | r[10], r[11]);
        end

        // R1: reset again with strap low
        @(negedge clk);
        strap_fullcop = 1'b0;
        rst_n = 1'b0;
        wr_en = 1'b0; ts_set = 1'b0; ts_clr = 1'b0; insn_vld = 1'b0;
        #1;
        chk("R1 reset word strap0", ctl_q, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        mdl = 32'h0;
        cyc(0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule